// File: doc/BRIEF.md
# Chained Scatter-Gather List Builder

This block turns a buffer description into a scatter-gather descriptor list in memory. The description is a byte offset into the first page, a total byte count, a page count and a stream of per-page bus addresses. Each page becomes a data piece. A piece that starts exactly where the previous data entry ends is folded into that entry, so a physically contiguous run needs only one descriptor. Two optional bounce addresses can stand in for a partial first page and a partial last page.

The list is laid out in blocks of eight 16-byte entries, 128 bytes per block. Slot 0 of every block links to the next block. Entries are collected in an eight-slot staging buffer, and a block is written to memory only when it is complete. When the pages run out, the final block is shifted down by one slot so that its link slot is overwritten. An end entry is placed after the last data entry, and only the slots that are in use are written.

The controller is a state machine with these states:
- `S_IDLE`: waits for `start`. On `start` it latches the configuration and goes to `S_OPEN`.
- `S_OPEN`: places the link entry in slot 0. It goes to `S_TAKE`, or to `S_SHIFT` when no pages remain.
- `S_TAKE`: consumes pages.
  - A page that cannot merge into a full block sends it to `S_FLUSH` without accepting the page.
  - Accepting the last page sends it to `S_SHIFT`.
- `S_FLUSH`: writes all eight slots, then goes to `S_OPEN` for the next block.
- `S_SHIFT`: shifts the final block down and inserts the end entry, then goes to `S_DRAIN`.
- `S_DRAIN`: writes the slots in use, then goes to `S_DONE`.
- `S_DONE`: pulses `done`, then returns to `S_IDLE`.

Top module: `sgl_chain_builder`

## Requirements
- R1: Out of reset, and whenever the block is not busy, `busy`, `done`, `wr_valid` and `pg_ready` are all low.
- R2: Every entry is written as one 128-bit word. Bits 127:64 hold the target address, bits 63:32 the length and bits 31:0 the flags. Bits 127:120 are byte 0 in memory, so the fields are big-endian. Slot s of block b is written at `cfg_base + 128*b + 16*s`.
- R3: Slot 0 of every block that is not the last one is a link entry. Its address is `cfg_base + 128*(b+1)`, its length is 128 and its flags are the link code (default 1).
- R4: A data entry carries the flags code 0 (default). Its length is min(remaining bytes, page size minus offset). The offset is added to the first page's address only and is zero for every later page.
- R5: A page whose address equals the end address of the previous data entry (its address plus its length) creates no new entry. It extends that entry's length instead.
- R6: In the final block, data entry k moves from slot k+1 to slot k. An end entry with address 0, length 0 and flags code 2 (default) follows the last data entry, and no slot after it is written.
- R7: When the last page merges into a block that already holds seven data entries, nothing is written to the next block. That block ends with its seven data entries in slots 0..6 and the end entry in slot 7.
- R8: With the first-page bounce enabled, page 0 uses `cfg_first_bnc` plus the offset. With the last-page bounce enabled, the last page uses `cfg_last_bnc`. The first-page rule wins when there is only one page.
- R9: Entries are written in ascending address order. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold.
- R10: `done` is high for exactly the one cycle after the end entry's write is accepted. `busy` falls in the following cycle.
- R11: `start` and all configuration inputs are ignored while `busy` is high.
- R12: Exactly one page beat is accepted per configured page, and `pg_ready` is only high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a list; sampled in idle only |
| cfg_base | input | 64 | Bus address of block 0 of the list |
| cfg_page_size | input | 32 | Page size in bytes |
| cfg_first_offs | input | 32 | Byte offset of the data in the first page |
| cfg_total | input | 32 | Total data bytes |
| cfg_pages | input | PGW | Number of pages to consume |
| cfg_first_bnc_en | input | 1 | Use the first-page bounce address |
| cfg_first_bnc | input | 64 | Bounce address for the first page |
| cfg_last_bnc_en | input | 1 | Use the last-page bounce address |
| cfg_last_bnc | input | 64 | Bounce address for the last page |
| pg_valid | input | 1 | Page address beat valid |
| pg_ready | output | 1 | Page address beat accepted |
| pg_addr | input | 64 | Bus address of the current page |
| wr_valid | output | 1 | Entry write request |
| wr_ready | input | 1 | Entry write accepted |
| wr_addr | output | 64 | Byte address of the entry |
| wr_data | output | 128 | Entry, big-endian |
| busy | output | 1 | List under construction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The sharpest collision is a page that both ends the list and merges into a block that is already full. Continuation and termination then fall in the same cycle, and the design must extend slot 7 and step back instead of opening a new block. The bench provokes this with eight pages whose last two are contiguous. It judges the result by the absence of any write to the second block, by the doubled length in the final data slot and by the end entry in slot 7. A second overlap, the flush of a full block while the next page waits unaccepted, is exercised under random write and page back-pressure. The bench compares every accepted write against a behavioural model of the list.

// File: rtl/sgl_pkg.sv
`timescale 1ns/1ps
package sgl_pkg;
    localparam int ADDR_W      = 64;
    localparam int LEN_W       = 32;
    localparam int FLAG_W      = 32;
    localparam int ENTRY_BYTES = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [FLAG_W-1:0] flags;
    } sgl_entry_t;

    typedef enum logic [2:0] {
        BUF_HOLD,
        BUF_CHAIN,
        BUF_PUT,
        BUF_GROW,
        BUF_SHIFT
    } buf_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPEN,
        S_TAKE,
        S_FLUSH,
        S_SHIFT,
        S_DRAIN,
        S_DONE
    } sgl_state_e;
endpackage

// File: rtl/sgl_stage_buf.sv
`timescale 1ns/1ps
module sgl_stage_buf
    import sgl_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  buf_op_e          op,
    input  logic [IW-1:0]    idx,
    input  sgl_entry_t       ent_in,
    input  logic [LEN_W-1:0] grow_len,
    input  logic [IW-1:0]    rd_idx,
    output sgl_entry_t       rd_ent
);
    sgl_entry_t slot_q [SLOTS];

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        sgl_entry_t q;
        sgl_entry_t above;
        if (gi < SLOTS - 1) begin : g_mid
            assign above = slot_q[gi+1];
        end else begin : g_top
            assign above = '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                unique case (op)
                    BUF_CHAIN: if (gi == 0) q <= ent_in;
                    BUF_PUT:   if (IW'(gi) == idx) q <= ent_in;
                    BUF_GROW:  if (IW'(gi) == idx) q.len <= q.len + grow_len;
                    BUF_SHIFT: begin
                        if (IW'(gi) == idx)     q <= ent_in;
                        else if (IW'(gi) < idx) q <= above;
                    end
                    default: ;
                endcase
            end
        end

        assign slot_q[gi] = q;
    end

    assign rd_ent = slot_q[rd_idx];
endmodule

// File: rtl/sgl_piece_calc.sv
`timescale 1ns/1ps
module sgl_piece_calc
    import sgl_pkg::*;
#(
    parameter int PGW = 16
) (
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic [PGW-1:0]    pg_idx,
    input  logic [PGW-1:0]    pg_total,
    input  logic              first_bnc_en,
    input  logic [ADDR_W-1:0] first_bnc,
    input  logic              last_bnc_en,
    input  logic [ADDR_W-1:0] last_bnc,
    input  logic [LEN_W-1:0]  offs,
    input  logic [LEN_W-1:0]  remain,
    input  logic [LEN_W-1:0]  pg_size,
    input  logic [ADDR_W-1:0] prev_end,
    input  logic              prev_ok,
    output logic [ADDR_W-1:0] daddr,
    output logic [LEN_W-1:0]  piece,
    output logic              merge
);
    logic [LEN_W-1:0] room;
    logic             is_first;
    logic             is_last;

    always_comb begin
        room     = pg_size - offs;
        piece    = (remain < room) ? remain : room;
        is_first = (pg_idx == '0);
        is_last  = (pg_idx == pg_total - PGW'(1));
        if (is_first && first_bnc_en)
            daddr = first_bnc + ADDR_W'(offs);
        else if (is_last && last_bnc_en)
            daddr = last_bnc;
        else
            daddr = pg_addr + ADDR_W'(offs);
        merge = prev_ok && (prev_end == daddr);
    end
endmodule

// File: rtl/sgl_chain_builder.sv
`timescale 1ns/1ps
module sgl_chain_builder
    import sgl_pkg::*;
#(
    parameter int SLOTS     = 8,
    parameter int PGW       = 16,
    parameter int BLKW      = 24,
    parameter int FLG_DATA  = 0,
    parameter int FLG_CHAIN = 1,
    parameter int FLG_END   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       cfg_base,
    input  logic [31:0]       cfg_page_size,
    input  logic [31:0]       cfg_first_offs,
    input  logic [31:0]       cfg_total,
    input  logic [PGW-1:0]    cfg_pages,
    input  logic              cfg_first_bnc_en,
    input  logic [63:0]       cfg_first_bnc,
    input  logic              cfg_last_bnc_en,
    input  logic [63:0]       cfg_last_bnc,
    input  logic              pg_valid,
    output logic              pg_ready,
    input  logic [63:0]       pg_addr,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [63:0]       wr_addr,
    output logic [127:0]      wr_data,
    output logic              busy,
    output logic              done
);
    localparam int IW        = $clog2(SLOTS);
    localparam int CW        = $clog2(SLOTS + 1);
    localparam int BLK_BYTES = SLOTS * ENTRY_BYTES;
    localparam int BLK_SH    = $clog2(BLK_BYTES);
    localparam int ENT_SH    = $clog2(ENTRY_BYTES);

    sgl_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q, fb_q, lb_q, prev_end_q;
    logic [LEN_W-1:0]  psz_q, remain_q, offs_q;
    logic [PGW-1:0]    pages_q, p_q;
    logic              fbe_q, lbe_q, prev_ok_q;
    logic [CW-1:0]     j_q;
    logic [BLKW-1:0]   blk_q;
    logic [IW-1:0]     last_q, wr_idx_q;

    logic [ADDR_W-1:0] daddr;
    logic [LEN_W-1:0]  piece;
    logic              merge;
    logic              full;
    logic              take;
    logic              wr_hs;

    buf_op_e           op;
    logic [IW-1:0]     op_idx;
    sgl_entry_t        ent_in;
    sgl_entry_t        rd_ent;

    sgl_piece_calc #(.PGW(PGW)) u_piece (
        .pg_addr      (pg_addr),
        .pg_idx       (p_q),
        .pg_total     (pages_q),
        .first_bnc_en (fbe_q),
        .first_bnc    (fb_q),
        .last_bnc_en  (lbe_q),
        .last_bnc     (lb_q),
        .offs         (offs_q),
        .remain       (remain_q),
        .pg_size      (psz_q),
        .prev_end     (prev_end_q),
        .prev_ok      (prev_ok_q),
        .daddr        (daddr),
        .piece        (piece),
        .merge        (merge)
    );

    sgl_stage_buf #(.SLOTS(SLOTS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .idx      (op_idx),
        .ent_in   (ent_in),
        .grow_len (piece),
        .rd_idx   (wr_idx_q),
        .rd_ent   (rd_ent)
    );

    assign full  = (j_q == CW'(SLOTS));
    assign wr_hs = wr_valid && wr_ready;
    assign take  = pg_valid && pg_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs and next state
    always_comb begin
        state_d  = state_q;
        pg_ready = 1'b0;
        wr_valid = 1'b0;
        op       = BUF_HOLD;
        op_idx   = '0;
        ent_in   = '0;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_OPEN;
            end
            S_OPEN: begin
                op           = BUF_CHAIN;
                ent_in.addr  = base_q + ((ADDR_W'(blk_q) + ADDR_W'(1)) << BLK_SH);
                ent_in.len   = LEN_W'(BLK_BYTES);
                ent_in.flags = FLAG_W'(FLG_CHAIN);
                state_d      = (p_q == pages_q) ? S_SHIFT : S_TAKE;
            end
            S_TAKE: begin
                pg_ready = !(full && !merge);
                if (pg_valid) begin
                    if (full && !merge) begin
                        state_d = S_FLUSH;
                    end else begin
                        op           = merge ? BUF_GROW : BUF_PUT;
                        op_idx       = merge ? last_q : j_q[IW-1:0];
                        ent_in.addr  = daddr;
                        ent_in.len   = piece;
                        ent_in.flags = FLAG_W'(FLG_DATA);
                        if ((p_q + PGW'(1)) == pages_q) state_d = S_SHIFT;
                    end
                end
            end
            S_FLUSH: begin
                wr_valid = 1'b1;
                if (wr_ready && wr_idx_q == IW'(SLOTS - 1)) state_d = S_OPEN;
            end
            S_SHIFT: begin
                op           = BUF_SHIFT;
                op_idx       = IW'(j_q - CW'(1));
                ent_in.addr  = '0;
                ent_in.len   = '0;
                ent_in.flags = FLAG_W'(FLG_END);
                state_d      = S_DRAIN;
            end
            S_DRAIN: begin
                wr_valid = 1'b1;
                if (wr_ready && wr_idx_q == IW'(j_q - CW'(1))) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign busy    = (state_q != S_IDLE);
    assign done    = (state_q == S_DONE);
    assign wr_addr = base_q + (ADDR_W'(blk_q) << BLK_SH) + (ADDR_W'(wr_idx_q) << ENT_SH);
    assign wr_data = {rd_ent.addr, rd_ent.len, rd_ent.flags};

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            fb_q       <= '0;
            lb_q       <= '0;
            prev_end_q <= '0;
            psz_q      <= '0;
            remain_q   <= '0;
            offs_q     <= '0;
            pages_q    <= '0;
            p_q        <= '0;
            fbe_q      <= 1'b0;
            lbe_q      <= 1'b0;
            prev_ok_q  <= 1'b0;
            j_q        <= '0;
            blk_q      <= '0;
            last_q     <= '0;
            wr_idx_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        base_q    <= cfg_base;
                        psz_q     <= cfg_page_size;
                        offs_q    <= cfg_first_offs;
                        remain_q  <= cfg_total;
                        pages_q   <= cfg_pages;
                        fbe_q     <= cfg_first_bnc_en;
                        fb_q      <= cfg_first_bnc;
                        lbe_q     <= cfg_last_bnc_en;
                        lb_q      <= cfg_last_bnc;
                        p_q       <= '0;
                        blk_q     <= '0;
                        j_q       <= '0;
                        prev_ok_q <= 1'b0;
                        wr_idx_q  <= '0;
                    end
                end
                S_OPEN: begin
                    j_q <= CW'(1);
                end
                S_TAKE: begin
                    if (take) begin
                        p_q        <= p_q + PGW'(1);
                        remain_q   <= remain_q - piece;
                        offs_q     <= '0;
                        prev_end_q <= daddr + ADDR_W'(piece);
                        prev_ok_q  <= 1'b1;
                        if (!merge) begin
                            last_q <= j_q[IW-1:0];
                            j_q    <= j_q + CW'(1);
                        end
                    end
                    wr_idx_q <= '0;
                end
                S_FLUSH: begin
                    if (wr_hs) begin
                        wr_idx_q <= wr_idx_q + IW'(1);
                        if (wr_idx_q == IW'(SLOTS - 1)) blk_q <= blk_q + BLKW'(1);
                    end
                end
                S_SHIFT: begin
                    wr_idx_q <= '0;
                end
                S_DRAIN: begin
                    if (wr_hs) wr_idx_q <= wr_idx_q + IW'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sgl_chain_builder_chk.sv
`timescale 1ns/1ps
module sgl_chain_builder_chk #(
    parameter int FLG_CHAIN = 1,
    parameter int FLG_END   = 2,
    parameter int SLOTS     = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         done,
    input logic         pg_ready,
    input logic         wr_valid,
    input logic         wr_ready,
    input logic [63:0]  wr_addr,
    input logic [127:0] wr_data
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !pg_ready && !done)); // R1

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R9

    AST_LINK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_data[31:0] == 32'(FLG_CHAIN)) |-> (wr_data[63:32] == 32'(SLOTS * 16))); // R3

    AST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_data[31:0] == 32'(FLG_END)) |-> (wr_data[127:32] == '0)); // R6

    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_valid && wr_ready && wr_data[31:0] == 32'(FLG_END))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

bind sgl_chain_builder sgl_chain_builder_chk #(
    .FLG_CHAIN (FLG_CHAIN),
    .FLG_END   (FLG_END),
    .SLOTS     (SLOTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .pg_ready (pg_ready),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/tb_sgl_chain_builder.sv
`timescale 1ns/1ps
module tb_sgl_chain_builder;
    localparam int PGW = 16;
    localparam int FD = 0, FC = 1, FE = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n, start;
    logic [63:0]    cfg_base, cfg_first_bnc, cfg_last_bnc, pg_addr, wr_addr;
    logic [31:0]    cfg_page_size, cfg_first_offs, cfg_total;
    logic [PGW-1:0] cfg_pages;
    logic           cfg_first_bnc_en, cfg_last_bnc_en;
    logic           pg_valid, pg_ready, wr_valid, wr_ready, busy, done;
    logic [127:0]   wr_data;

    sgl_chain_builder #(.PGW(PGW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_base(cfg_base), .cfg_page_size(cfg_page_size),
        .cfg_first_offs(cfg_first_offs), .cfg_total(cfg_total),
        .cfg_pages(cfg_pages),
        .cfg_first_bnc_en(cfg_first_bnc_en), .cfg_first_bnc(cfg_first_bnc),
        .cfg_last_bnc_en(cfg_last_bnc_en), .cfg_last_bnc(cfg_last_bnc),
        .pg_valid(pg_valid), .pg_ready(pg_ready), .pg_addr(pg_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    int checks = 0, errors = 0;
    logic [63:0]  exp_addr[$];
    logic [127:0] exp_data[$];
    logic [63:0]  pg_list[$];
    logic [63:0]  j_base, j_fb, j_lb;
    logic [31:0]  j_psz, j_offs, j_total;
    int           j_np;
    bit           j_fbe, j_lbe;
    int           pg_k = 0;
    bit           job_on = 0, exp_done = 0, hung = 0, hold_chk = 0;
    logic [63:0]  hold_a;
    int           done_cnt = 0;
    logic [15:0]  lf = 16'hACE1;
    string        cur_tag = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic void build_expected();
        logic [63:0] ea [int];
        logic [31:0] el [int];
        logic [31:0] ef [int];
        logic [63:0] d, prev;
        logic [31:0] remain, offs, room, piece;
        int b, j, last, n;
        bit pv;
        b = 0; j = 1; last = 0; pv = 0; prev = '0;
        ea[0] = j_base + 64'd128; el[0] = 32'd128; ef[0] = FC;
        remain = j_total; offs = j_offs;
        for (int k = 0; k < j_np; k++) begin
            room  = j_psz - offs;
            piece = (remain < room) ? remain : room;
            if (k == 0 && j_fbe)             d = j_fb + 64'(offs);
            else if (k == j_np - 1 && j_lbe) d = j_lb;
            else                             d = pg_list[k] + 64'(offs);
            if (pv && prev == d) begin
                el[last] = el[last] + piece;
            end else begin
                if (j == 8) begin
                    b++;
                    ea[b*8] = j_base + 64'(128 * (b + 1)); el[b*8] = 32'd128; ef[b*8] = FC;
                    j = 1;
                end
                ea[b*8+j] = d; el[b*8+j] = piece; ef[b*8+j] = FD;
                last = b*8 + j;
                j++;
            end
            remain = remain - piece; offs = '0;
            prev = d + 64'(piece); pv = 1;
        end
        n = j - 1;
        for (int i = 0; i < n; i++) begin
            ea[b*8+i] = ea[b*8+i+1]; el[b*8+i] = el[b*8+i+1]; ef[b*8+i] = ef[b*8+i+1];
        end
        ea[b*8+n] = '0; el[b*8+n] = '0; ef[b*8+n] = FE;
        exp_addr.delete(); exp_data.delete();
        for (int bb = 0; bb <= b; bb++) begin
            for (int s = 0; s < ((bb == b) ? n + 1 : 8); s++) begin
                exp_addr.push_back(j_base + 64'(bb * 128 + s * 16));
                exp_data.push_back({ea[bb*8+s], el[bb*8+s], ef[bb*8+s]});
            end
        end
    endfunction

    // driver and per-clock comparison against the model
    initial begin
        wr_ready = 1'b0; pg_valid = 1'b0; pg_addr = '0;
        forever begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            wr_ready = lf[0] | lf[1];
            if (job_on && pg_k < j_np) begin
                pg_valid = lf[2] | lf[3];
                pg_addr  = pg_list[pg_k];
            end else begin
                pg_valid = 1'b0;
            end
            #1;
            check(done == exp_done, "R10", "done timing", 128'(done), 128'(exp_done));
            exp_done = 0;
            if (done) done_cnt++;
            if (hold_chk) begin
                check(wr_valid && wr_addr == hold_a, "R9", "write held", wr_addr, hold_a);
                hold_chk = 0;
            end
            if (wr_valid && !wr_ready) begin
                hold_chk = 1; hold_a = wr_addr;
            end
            if (wr_valid && wr_ready) begin
                if (exp_addr.size() == 0) begin
                    check(0, "R6", "write past end of list", wr_addr, '0);
                end else begin
                    string ft;
                    ft = (exp_data[0][31:0] == FC) ? "R3" : (exp_data[0][31:0] == FE) ? "R6" : "R4";
                    check(wr_addr == exp_addr[0], $sformatf("%s/R2/R9", cur_tag), "entry address",
                          wr_addr, exp_addr[0]);
                    check(wr_data == exp_data[0], $sformatf("%s/%s", cur_tag, ft), "entry data",
                          wr_data, exp_data[0]);
                    if (exp_data[0][31:0] == FE) exp_done = 1;
                    void'(exp_addr.pop_front());
                    void'(exp_data.pop_front());
                end
            end
            if (pg_valid && pg_ready) pg_k++;
        end
    end

    task automatic run_job(input string tag, input bit poke);
        int base_done, cyc;
        if (hung) return;
        cur_tag = tag;
        build_expected();
        @(negedge clk); #1.5;
        cfg_base = j_base; cfg_page_size = j_psz; cfg_first_offs = j_offs;
        cfg_total = j_total; cfg_pages = PGW'(j_np);
        cfg_first_bnc_en = j_fbe; cfg_first_bnc = j_fb;
        cfg_last_bnc_en = j_lbe; cfg_last_bnc = j_lb;
        pg_k = 0; job_on = 1; start = 1'b1;
        base_done = done_cnt;
        @(negedge clk); #1.5;
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            #1.5;
            check(busy == 1'b1, "R11", "busy before second start", 128'(busy), 128'(1));
            cfg_base = j_base ^ 64'h0100_0000; cfg_pages = PGW'(1); cfg_total = 32'd5;
            cfg_first_bnc_en = 1'b1; start = 1'b1;
            @(negedge clk); #1.5;
            start = 1'b0;
        end
        cyc = 0;
        while (done_cnt == base_done && !hung) begin
            @(negedge clk); #1.5;
            cyc++;
            if (cyc > 20000) begin
                hung = 1; checks++; errors++;
                $display("FAIL %s watchdog expired actual=%0d expected=%0d", tag, cyc, 0);
            end
        end
        job_on = 0;
        check(exp_addr.size() == 0, $sformatf("%s/R6", tag), "entries still expected",
              128'(exp_addr.size()), 128'(0));
        check(pg_k == j_np, "R12", "page beats accepted", 128'(pg_k), 128'(j_np));
        @(negedge clk); #1.5;
        check(!busy && !done, "R10", "idle after done", 128'({busy, done}), 128'(0));
    endtask

    task automatic set_job(input logic [63:0] base, input logic [31:0] psz,
                           input logic [31:0] offs, input logic [31:0] total, input int np);
        j_base = base; j_psz = psz; j_offs = offs; j_total = total; j_np = np;
        j_fbe = 0; j_lbe = 0; j_fb = '0; j_lb = '0;
        pg_list.delete();
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0;
        cfg_base = '0; cfg_page_size = '0; cfg_first_offs = '0; cfg_total = '0;
        cfg_pages = '0; cfg_first_bnc_en = 0; cfg_first_bnc = '0;
        cfg_last_bnc_en = 0; cfg_last_bnc = '0;
        repeat (3) @(negedge clk);
        #1.5;
        check(!busy && !done && !wr_valid && !pg_ready, "R1", "outputs in reset",
              128'({busy, done, wr_valid, pg_ready}), 128'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1.5;
        check(!busy && !done && !wr_valid && !pg_ready, "R1", "outputs after reset",
              128'({busy, done, wr_valid, pg_ready}), 128'(0));

        // R4: single partial page with offset
        set_job(64'h1000_0000, 32'd4096, 32'h100, 32'h200, 1);
        pg_list.push_back(64'h0001_0000);
        run_job("R4", 0);

        // R5: four contiguous pages fold into one entry
        set_job(64'h1000_1000, 32'd4096, 32'h80, 32'd16384 - 32'h180, 4);
        for (int k = 0; k < 4; k++) pg_list.push_back(64'h0002_0000 + 64'(k * 4096));
        run_job("R5", 0);

        // R6: seven scattered pages fill one block exactly
        set_job(64'h1000_2000, 32'd4096, 32'h0, 32'd7 * 4096, 7);
        for (int k = 0; k < 7; k++) pg_list.push_back(64'h0100_0000 + 64'(k * 32'h10000));
        run_job("R6", 0);

        // R3: eight scattered pages need a second block
        set_job(64'h1000_3000, 32'd4096, 32'h0, 32'd8 * 4096, 8);
        for (int k = 0; k < 8; k++) pg_list.push_back(64'h0200_0000 + 64'(k * 32'h10000));
        run_job("R3", 0);

        // R7: last page merges into a full block, step back
        set_job(64'h1000_4000, 32'd4096, 32'h0, 32'd8 * 4096, 8);
        for (int k = 0; k < 7; k++) pg_list.push_back(64'h0300_0000 + 64'(k * 32'h10000));
        pg_list.push_back(64'h0300_0000 + 64'(6 * 32'h10000) + 64'd4096);
        run_job("R7", 0);

        // R8: bounce addresses replace first and last pages
        set_job(64'h1000_5000, 32'd4096, 32'h300, 32'h2200, 3);
        j_fbe = 1; j_fb = 64'h7000_0000; j_lbe = 1; j_lb = 64'h7100_0000;
        pg_list.push_back(64'h0020_0000);
        pg_list.push_back(64'h0020_3000);
        pg_list.push_back(64'h0020_4000);
        run_job("R8", 0);

        // R5: small pages in contiguous pairs across two blocks
        set_job(64'h1000_6000, 32'd512, 32'h40, 32'd20 * 512 - 32'h50, 20);
        for (int k = 0; k < 20; k++)
            pg_list.push_back(64'h0040_0000 + 64'((k / 2) * 32'h8000) + 64'((k % 2) * 512));
        run_job("R5", 0);

        // R11: second start while busy is ignored
        set_job(64'h1000_7000, 32'd4096, 32'h10, 32'd7 * 4096 - 32'h10, 7);
        for (int k = 0; k < 7; k++) pg_list.push_back(64'h0500_0000 + 64'(k * 32'h20000));
        run_job("R11", 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule